// File: doc/BRIEF.md
# Switching Cycle Timebase with Master/Slave Synchronization

This block produces the switching-cycle timebase for one converter and lets several converters run in lock-step. A counter-based oscillator emits a one-cycle cycle-start strobe at a programmed period. A static strap picks the role of the converter. The role is captured once, on the first enable after reset. A master drives the shared clock pin. Once power-good is high, it places a short fixed-width pulse on that pin half a period after each cycle start, so slaves switch roughly 180 degrees out of phase.

A slave leaves the clock pin undriven. It samples the pin through a two-stage synchronizer and re-phases its own oscillator on each rising edge, but only while power-good is high. Its free-running period is about 10% longer than the master period for the same setting. Between edges, or with no master present, it keeps switching at that slower rate. A lock flag shows whether the last cycle was started by an external edge. The flag drops when the oscillator reaches its own wrap with no edge, and the strobe train continues without a gap or a runt cycle.

Top module: `sw_sync_timebase`

## Requirements
- R1: The role is captured from `strap_slave` (0 = master, 1 = slave) at the first clock edge after reset at which `enable` is sampled high. Later changes of `strap_slave`, including across disable and re-enable, have no effect until reset.
- R2: `sync_oe` is 1 exactly when the captured role is master. In slave role, `sync_oe` and `sync_out` stay 0.
- R3: `cycle_start` is high for one cycle. The first strobe appears in the cycle after the edge that samples `enable` high. In master role, strobes repeat every P cycles, where P = max(`period_in`, MIN_PERIOD). No strobe appears while `enable` is low.
- R4: In master role, `sync_out` is high for PULSE_W consecutive cycles, starting floor(P/2) cycles after the cycle in which `cycle_start` is high.
- R5: A master pulse starts only if `pgood` is high at its launch edge, one cycle before the pulse. A pulse already under way completes its full width even if `pgood` falls.
- R6: In slave role with no accepted edge, strobes repeat every P + floor(P*STRETCH_NUM / 2^STRETCH_SHIFT) cycles. With the defaults 13 and 7 this is P + floor(13P/128).
- R7: In slave role with `pgood` high, if `sync_in` is sampled 0 and then 1 at edge A, then `cycle_start` and `locked` are high in the cycle after edge A+2.
- R8: An accepted edge that arrives while the oscillator is already in its cycle-start cycle adds no second strobe. It still sets `locked`, and the cycle keeps its full length.
- R9: In slave role with `pgood` low, rising edges on `sync_in` leave the strobe timing unchanged, and `locked` stays 0.
- R10: `locked` clears at the free-running wrap that no edge pre-empted. That wrap's strobe comes one full slave period after the previous strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; the first high sample captures the role |
| strap_slave | input | 1 | Static role strap: 0 master, 1 slave |
| pgood | input | 1 | Output-in-regulation flag; gates pulse launch and edge acceptance |
| period_in | input | CNT_W | Programmed master period in clock cycles |
| sync_in | input | 1 | Clock pin receive path, asynchronous |
| cycle_start | output | 1 | One-cycle strobe at the start of each switching cycle |
| sync_out | output | 1 | Clock pin drive value |
| sync_oe | output | 1 | Clock pin output enable |
| locked | output | 1 | Slave: the current cycle was started by an accepted edge |

## Verification
The bench builds the block with CNT_W=8, MIN_PERIOD=10 and PULSE_W=3. With these values the clamp of small periods, odd-period halving, the largest 8-bit period and the truncation in the slave stretch all fall within a few hundred cycles. A 3-cycle pulse leaves room to drop power-good in mid-pulse. The narrow period range makes it possible to time an external edge so that it lands on the very cycle-start cycle or just before a free-running wrap.

// File: rtl/swsync_pkg.sv
package swsync_pkg;

   typedef enum logic {
      MODE_MASTER = 1'b0,
      MODE_SLAVE  = 1'b1
   } mode_t;

endpackage

// File: rtl/swsync_role.sv
module swsync_role
   import swsync_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  enable,
   input  logic  strap_slave,
   output logic  run,
   output logic  role_valid,
   output mode_t role,
   output logic  pin_drive_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run          <= 1'b0;
         role_valid   <= 1'b0;
         role         <= MODE_MASTER;
         pin_drive_en <= 1'b0;
      end else begin
         run <= enable;
         if (enable && !role_valid) begin
            role_valid   <= 1'b1;
            role         <= strap_slave ? MODE_SLAVE : MODE_MASTER;
            pin_drive_en <= !strap_slave;
         end
      end
   end

endmodule

// File: rtl/swsync_edge_sync.sv
module swsync_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic rise
);

   logic [STAGES-1:0] shreg;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("swsync_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         last_q <= 1'b0;
      end else begin
         shreg  <= {shreg[STAGES-2:0], d_async};
         last_q <= shreg[STAGES-1];
      end
   end

   assign rise = shreg[STAGES-1] & ~last_q;

endmodule

// File: rtl/swsync_osc.sv
module swsync_osc #(
   parameter int CNT_W         = 12,
   parameter int MIN_PERIOD    = 40,
   parameter int STRETCH_NUM   = 13,
   parameter int STRETCH_SHIFT = 7,
   localparam int PER_W        = CNT_W + 1,
   localparam int PROD_W       = PER_W + STRETCH_SHIFT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             slave,
   input  logic             rephase,
   input  logic [CNT_W-1:0] period_in,
   output logic [PER_W-1:0] cnt,
   output logic [PER_W-1:0] half_p,
   output logic             wrap
);

   logic [PER_W-1:0] eff_p;
   logic [PER_W-1:0] stretch;
   logic [PER_W-1:0] lim;

   always_comb begin
      if (PER_W'(period_in) < PER_W'(MIN_PERIOD)) eff_p = PER_W'(MIN_PERIOD);
      else                                        eff_p = PER_W'(period_in);
   end

   if (STRETCH_NUM == 0) begin : g_no_stretch
      assign stretch = '0;
   end else begin : g_stretch
      logic [PROD_W-1:0] prod;
      assign prod    = PROD_W'(eff_p) * PROD_W'(STRETCH_NUM);
      assign stretch = PER_W'(prod >> STRETCH_SHIFT);
   end

   assign lim    = slave ? (eff_p + stretch) : eff_p;
   assign half_p = eff_p >> 1;
   assign wrap   = run && (cnt >= lim - PER_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (!run)                      cnt <= '0;
      else if (rephase && cnt != '0)      cnt <= '0;
      else if (wrap)                      cnt <= '0;
      else                                cnt <= cnt + PER_W'(1);
   end

endmodule

// File: rtl/swsync_pulse.sv
module swsync_pulse #(
   parameter int PULSE_W = 17,
   localparam int PW_W   = $clog2(PULSE_W + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic kill,
   output logic pulse
);

   if (PULSE_W < 1) begin : g_bad_width
      $error("swsync_pulse: PULSE_W must be at least 1");
   end

   if (PULSE_W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    pulse <= 1'b0;
         else if (kill) pulse <= 1'b0;
         else           pulse <= fire;
      end
   end else begin : g_multi
      logic [PW_W-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            left <= '0;
         else if (kill)         left <= '0;
         else if (fire)         left <= PW_W'(PULSE_W);
         else if (left != '0)   left <= left - PW_W'(1);
      end
      assign pulse = (left != '0);
   end

endmodule

// File: rtl/sw_sync_timebase.sv
module sw_sync_timebase
   import swsync_pkg::*;
#(
   parameter int CNT_W         = 12,
   parameter int MIN_PERIOD    = 40,
   parameter int PULSE_W       = 17,
   parameter int STRETCH_NUM   = 13,
   parameter int STRETCH_SHIFT = 7,
   parameter int SYNC_STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             strap_slave,
   input  logic             pgood,
   input  logic [CNT_W-1:0] period_in,
   input  logic             sync_in,
   output logic             cycle_start,
   output logic             sync_out,
   output logic             sync_oe,
   output logic             locked
);

   localparam int PER_W = CNT_W + 1;

   if (MIN_PERIOD < 2 * (PULSE_W + 1)) begin : g_bad_min
      $error("sw_sync_timebase: MIN_PERIOD too small for PULSE_W");
   end
   if (MIN_PERIOD >= (1 << CNT_W)) begin : g_bad_cnt
      $error("sw_sync_timebase: MIN_PERIOD does not fit CNT_W");
   end
   if (STRETCH_NUM < 0 || STRETCH_NUM >= (1 << STRETCH_SHIFT)) begin : g_bad_stretch
      $error("sw_sync_timebase: STRETCH_NUM must be below 2**STRETCH_SHIFT");
   end

   logic             run;
   logic             role_valid;
   mode_t            role;
   logic             is_slave;
   logic             edge_rise;
   logic             accept;
   logic [PER_W-1:0] cnt;
   logic [PER_W-1:0] half_p;
   logic             wrap;
   logic             fire;

   swsync_role u_role (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .strap_slave  (strap_slave),
      .run          (run),
      .role_valid   (role_valid),
      .role         (role),
      .pin_drive_en (sync_oe)
   );

   assign is_slave = (role == MODE_SLAVE);

   swsync_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (sync_in),
      .rise    (edge_rise)
   );

   assign accept = run && is_slave && pgood && edge_rise;

   swsync_osc #(
      .CNT_W         (CNT_W),
      .MIN_PERIOD    (MIN_PERIOD),
      .STRETCH_NUM   (STRETCH_NUM),
      .STRETCH_SHIFT (STRETCH_SHIFT)
   ) u_osc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .slave     (is_slave),
      .rephase   (accept),
      .period_in (period_in),
      .cnt       (cnt),
      .half_p    (half_p),
      .wrap      (wrap)
   );

   assign cycle_start = run && (cnt == '0);

   assign fire = run && !is_slave && pgood && (cnt == half_p - PER_W'(1));

   swsync_pulse #(.PULSE_W(PULSE_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .kill  (!run),
      .pulse (sync_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          locked <= 1'b0;
      else if (!run || !is_slave || !pgood) locked <= 1'b0;
      else if (accept)                     locked <= 1'b1;
      else if (wrap)                       locked <= 1'b0;
   end

endmodule

// File: rtl/sw_sync_timebase_chk.sv
module sw_sync_timebase_chk #(
   parameter int PER_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             pgood,
   input logic             cycle_start,
   input logic             sync_out,
   input logic             sync_oe,
   input logic             locked,
   input logic             role_valid,
   input logic             is_slave,
   input logic             run,
   input logic [PER_W-1:0] cnt,
   input logic [PER_W-1:0] half_p,
   input logic             wrap,
   input logic             accept
);

   assert_role_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      role_valid |=> (role_valid && $stable(is_slave)));

   assert_slave_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (role_valid && is_slave) |-> (!sync_oe && !sync_out));

   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start |=> !cycle_start);

   assert_idle_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !cycle_start);

   assert_pulse_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_out) |-> (cnt == half_p));

   assert_pulse_pgood_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_out) |-> $past(pgood));

   assert_rephase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && cnt != '0 && enable) |=> (cycle_start && locked));

   assert_no_lock_low_pg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pgood |=> !locked);

   assert_lock_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wrap && !accept) |=> !locked);

endmodule

bind sw_sync_timebase sw_sync_timebase_chk #(.PER_W(PER_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .pgood       (pgood),
   .cycle_start (cycle_start),
   .sync_out    (sync_out),
   .sync_oe     (sync_oe),
   .locked      (locked),
   .role_valid  (role_valid),
   .is_slave    (is_slave),
   .run         (run),
   .cnt         (cnt),
   .half_p      (half_p),
   .wrap        (wrap),
   .accept      (accept)
);

// File: tb/test_sw_sync_timebase.sv
`timescale 1ns/1ps
module test_sw_sync_timebase;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       strap_slave = 1'b0;
   logic       pgood = 1'b0;
   logic [7:0] period_in = 8'd20;
   logic       sync_in = 1'b0;
   logic       cycle_start, sync_out, sync_oe, locked;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   sw_sync_timebase #(
      .CNT_W      (8),
      .MIN_PERIOD (10),
      .PULSE_W    (3)
   ) i_sw_sync_timebase (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (enable),
      .strap_slave (strap_slave),
      .pgood       (pgood),
      .period_in   (period_in),
      .sync_in     (sync_in),
      .cycle_start (cycle_start),
      .sync_out    (sync_out),
      .sync_oe     (sync_oe),
      .locked      (locked)
   );

   // columns: slave, period_in, pgood, strobe period, pulse offset, pulse width
   localparam int NV = 9;
   localparam int VEC [NV][6] = '{
      '{0,  20, 1,  20,  10, 3},
      '{0,  21, 1,  21,  10, 3},
      '{0,   5, 1,  10,   5, 3},
      '{0,  20, 0,  20,   0, 0},
      '{1,  20, 1,  22,   0, 0},
      '{1,  40, 1,  44,   0, 0},
      '{1, 100, 1, 110,   0, 0},
      '{0, 255, 1, 255, 127, 3},
      '{1,   5, 1,  11,   0, 0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic adv(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; enable = 1'b0; sync_in = 1'b0;
      adv(3);
      rst_n = 1'b1;
      adv(1);
   endtask

   task automatic wait_start(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cycle_start && n < 1000);
   endtask

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      int t;
      int first;
      int width;
      int cnt_hi;

      // reset state
      adv(2);
      chk("R3 reset strobe", int'(cycle_start), 0);
      chk("R2 reset oe", int'(sync_oe), 0);
      chk("R4 reset pulse", int'(sync_out), 0);
      chk("R10 reset locked", int'(locked), 0);
      rst_n = 1'b1;

      // vector table
      for (int v = 0; v < NV; v++) begin
         do_reset();
         strap_slave = VEC[v][0][0];
         period_in   = 8'(VEC[v][1]);
         pgood       = VEC[v][2][0];
         enable      = 1'b1;
         wait_start(n);
         if (v == 0) chk("R3 first strobe delay", n, 1);
         t = 0; first = -1; width = 0;
         do begin
            @(negedge clk);
            t++;
            if (sync_out) begin
               if (first < 0) first = t;
               width++;
            end
         end while (!cycle_start && t < 400);
         chk(VEC[v][0] != 0 ? "R6 slave period" : "R3 master period", t, VEC[v][3]);
         chk(VEC[v][2] != 0 ? "R4 pulse width" : "R5 no pulse without pgood", width, VEC[v][5]);
         if (VEC[v][5] > 0) chk("R4 pulse offset", first, VEC[v][4]);
         chk("R2 oe by role", int'(sync_oe), (VEC[v][0] != 0) ? 0 : 1);
      end

      // R1: strap change after capture ignored, even across re-enable
      do_reset();
      strap_slave = 1'b0; period_in = 8'd20; pgood = 1'b1; enable = 1'b1;
      wait_start(n);
      strap_slave = 1'b1;
      adv(25);
      chk("R1 oe after strap change", int'(sync_oe), 1);
      enable = 1'b0;
      adv(1);
      cnt_hi = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (cycle_start) cnt_hi++;
      end
      chk("R3 no strobe while disabled", cnt_hi, 0);
      enable = 1'b1;
      wait_start(n);
      chk("R3 strobe after re-enable", n, 1);
      chk("R1 role kept after re-enable", int'(sync_oe), 1);
      width = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (sync_out) width++;
      end
      chk("R1 master pulses kept", width, 3);

      // R5: pgood falls mid-pulse
      do_reset();
      strap_slave = 1'b0; period_in = 8'd20; pgood = 1'b1; enable = 1'b1;
      wait_start(n);
      adv(11);
      chk("R5 pulse high t11", int'(sync_out), 1);
      pgood = 1'b0;
      adv(1);
      chk("R5 pulse completes", int'(sync_out), 1);
      adv(1);
      chk("R5 pulse ends", int'(sync_out), 0);
      adv(7);
      chk("R3 strobe t20", int'(cycle_start), 1);
      adv(2);
      pgood = 1'b1;
      adv(8);
      chk("R5 pulse resumes", int'(sync_out), 1);

      // R7: slave re-phase latency and lock
      do_reset();
      strap_slave = 1'b1; period_in = 8'd20; pgood = 1'b1; enable = 1'b1;
      wait_start(n);
      adv(5);
      sync_in = 1'b1;
      adv(1);
      chk("R7 no strobe yet t6", int'(cycle_start), 0);
      adv(1);
      chk("R7 no strobe yet t7", int'(cycle_start), 0);
      adv(1);
      chk("R7 strobe after edge", int'(cycle_start), 1);
      chk("R7 locked set", int'(locked), 1);
      sync_in = 1'b0;
      for (int k = 0; k < 3; k++) begin
         adv(17);
         sync_in = 1'b1;
         adv(2);
         chk("R7 tracked no early strobe", int'(cycle_start), 0);
         sync_in = 1'b0;
         adv(1);
         chk("R7 tracked strobe", int'(cycle_start), 1);
         chk("R7 tracked locked", int'(locked), 1);
         chk("R2 slave pin idle", int'(sync_out) + int'(sync_oe), 0);
      end

      // R10: loss of sync
      adv(21);
      chk("R10 still locked t21", int'(locked), 1);
      chk("R10 no strobe t21", int'(cycle_start), 0);
      adv(1);
      chk("R10 free-run strobe", int'(cycle_start), 1);
      chk("R10 lock cleared", int'(locked), 0);

      // R8: edge landing on the cycle-start cycle
      adv(20);
      sync_in = 1'b1;
      adv(2);
      chk("R8 natural strobe", int'(cycle_start), 1);
      sync_in = 1'b0;
      adv(1);
      chk("R8 no second strobe", int'(cycle_start), 0);
      chk("R8 locked", int'(locked), 1);
      adv(21);
      chk("R8 full cycle length", int'(cycle_start), 1);

      // R9: edges ignored without pgood
      pgood = 1'b0;
      adv(5);
      sync_in = 1'b1;
      adv(2);
      sync_in = 1'b0;
      adv(1);
      chk("R9 no rephase t8", int'(cycle_start), 0);
      chk("R9 not locked", int'(locked), 0);
      adv(14);
      chk("R9 free-run strobe kept", int'(cycle_start), 1);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule